// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug unit. Its inputs are event pulses: single-cycle hits from the address and data comparators, an external instruction tag, a breakpoint request raised by software on a second bus master, and an immediate software trigger. It walks a chain of four states. When the chain reaches the last state, the block raises the trigger that starts or ends a trace session. On the same entry it can also raise one breakpoint request.

Each of the three non-final states has its own configuration field. The field picks which event source advances the state, which state comes next, and whether the event is tagged or forced. A tagged event advances the sequencer in the same cycle it is presented. This models a tag that travels with an opcode and fires just before that opcode executes. A forced event is held as pending and advances the sequencer only on the first instruction boundary that comes after the hit.

A level arm input starts the chain. While it is low, the sequencer is held in the first state and all pending work is dropped.

Top module: `trig_sequencer`

## Requirements
- R1: While `arm` is low (and after reset), `seq_state` reads 0 (the first state). `trig`, `brk_dbg`, `brk_swi` and `brk_sec` are all low.
- R2: Each non-final state N (0..2) has a field `cfg[N*FW +: FW]`, where FW = SW+3 and SW = $clog2(NCMP+1). The field is laid out, MSB first, as {tagged, next[1:0], sel[SW-1:0]}. With tagged=1, a selected event in cycle c moves `seq_state` to `next` at the clock edge that ends cycle c.
- R3: With tagged=0 (forced), a selected event only sets a pending flag. The state moves to `next` at the edge that ends the first later cycle in which `ibound` is high.
- R4: A forced event that arrives in the same cycle as `ibound` does not advance the state at that edge.
- R5: `sel` values 0..NCMP-1 pick `cmp_hit[sel]`. `sel` = NCMP picks `ext_tag`. Larger values pick no source, and the state never advances through them.
- R6: `sw_trig` high in any non-final state moves `seq_state` to 3 (the final state) at the next edge, with priority over other events.
- R7: On the edge that enters state 3, `trig` goes high for exactly one cycle. The sequencer then stays in state 3 and ignores all events until `arm` goes low.
- R8: On entry to state 3, `bp_mode` selects which one-cycle breakpoint pulse is raised: 00 none, 01 `brk_dbg` (debug mode entry), 10 `brk_swi` (software interrupt), 11 `brk_sec` (second-master breakpoint).
- R9: While armed, `sec_bp_req` in cycle c raises `brk_sec` for cycle c+1. While disarmed, it is ignored.
- R10: Disarming clears a pending forced event. After re-arming, an `ibound` does not advance the state.
- R11: The `next` field may name any state, including an earlier one. The chain follows the programmed order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Sequencer enable; low holds the first state |
| cfg | input | 3*FW | Per-state fields {tagged, next, sel} for states 0..2 |
| bp_mode | input | 2 | Breakpoint raised on entering the final state |
| cmp_hit | input | NCMP | Comparator match pulses |
| ext_tag | input | 1 | External instruction tag, aligned to execution start |
| ibound | input | 1 | Instruction boundary strobe |
| sw_trig | input | 1 | Immediate software trigger |
| sec_bp_req | input | 1 | Software breakpoint request from the second bus master |
| seq_state | output | 2 | Current state, 3 is final |
| trig | output | 1 | Session trigger pulse |
| brk_dbg | output | 1 | Debug mode entry request |
| brk_swi | output | 1 | Software interrupt request |
| brk_sec | output | 1 | Second-master breakpoint request |

## Verification
The bench uses the default NCMP = 4, so each `sel` field is three bits wide. With that width, value 4 selects the external tag and values 5 to 7 are unmapped, so all of these codes can be driven. Four comparators are enough to show that a hit on a source that is not selected leaves the state unchanged. The two-bit `next` field lets the bench program backward and skipping chains and reach the final state both through the chain and by the software trigger.

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
  parameter int NCMP = 4,
  localparam int SW = $clog2(NCMP + 1),
  localparam int FW = SW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [3*FW-1:0] cfg,
  input  logic [1:0]      bp_mode,
  input  logic [NCMP-1:0] cmp_hit,
  input  logic            ext_tag,
  input  logic            ibound,
  input  logic            sw_trig,
  input  logic            sec_bp_req,
  output logic [1:0]      seq_state,
  output logic            trig,
  output logic            brk_dbg,
  output logic            brk_swi,
  output logic            brk_sec
);

  localparam logic [1:0] FINAL = 2'd3;

  logic [1:0]    st, nst;
  logic          pend, npend;
  logic [FW-1:0] fld;
  logic          f_tag;
  logic [1:0]    f_nxt;
  logic [SW-1:0] f_sel;
  logic          src, fire, adv, enter;

  always_comb begin
    case (st)
      2'd0:    fld = cfg[0*FW +: FW];
      2'd1:    fld = cfg[1*FW +: FW];
      2'd2:    fld = cfg[2*FW +: FW];
      default: fld = '0;
    endcase
  end

  assign f_tag = fld[FW-1];
  assign f_nxt = fld[FW-2 -: 2];
  assign f_sel = fld[SW-1:0];

  always_comb begin
    src = (f_sel == SW'(NCMP)) ? ext_tag : 1'b0;
    for (int i = 0; i < NCMP; i++)
      if (f_sel == SW'(i)) src = cmp_hit[i];
  end

  assign fire = f_tag ? src : (pend & ibound);

  always_comb begin
    nst = st;
    adv = 1'b0;
    if (st != FINAL) begin
      if (sw_trig) begin
        nst = FINAL;
        adv = 1'b1;
      end else if (fire) begin
        nst = f_nxt;
        adv = 1'b1;
      end
    end
  end

  assign npend = (st != FINAL) && !adv && (pend || (!f_tag && src));
  assign enter = (st != FINAL) && (nst == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0; pend <= 1'b0; trig <= 1'b0;
      brk_dbg <= 1'b0; brk_swi <= 1'b0; brk_sec <= 1'b0;
    end else if (!arm) begin
      st <= '0; pend <= 1'b0; trig <= 1'b0;
      brk_dbg <= 1'b0; brk_swi <= 1'b0; brk_sec <= 1'b0;
    end else begin
      st      <= nst;
      pend    <= npend;
      trig    <= enter;
      brk_dbg <= enter && (bp_mode == 2'b01);
      brk_swi <= enter && (bp_mode == 2'b10);
      brk_sec <= (enter && (bp_mode == 2'b11)) || sec_bp_req;
    end
  end

  assign seq_state = st;

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (seq_state == 2'd0 && !trig && !brk_dbg && !brk_swi && !brk_sec));

  a_r2_tagged_step: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && st != FINAL && !sw_trig && f_tag && src) |=> (seq_state == $past(f_nxt)));

  a_r4_forced_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && st != FINAL && !sw_trig && !f_tag && !pend) |=> $stable(seq_state));

  a_r6_sw_final: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && sw_trig) |=> (seq_state == FINAL));

  a_r7_hold_final: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && seq_state == FINAL) |=> (seq_state == FINAL && !trig));

  a_r7_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (seq_state == FINAL));

  a_r8_one_bp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_dbg, brk_swi}) && !(brk_dbg && !trig) && !(brk_swi && !trig));

  a_r9_sec_bp: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && sec_bp_req) |=> brk_sec);

endmodule

// File: tb/test_trig_sequencer.sv
module test_trig_sequencer;
  localparam int NCMP = 4;
  localparam int SW = $clog2(NCMP + 1);
  localparam int FW = SW + 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            arm = 1'b0;
  logic [3*FW-1:0] cfg = '0;
  logic [1:0]      bp_mode = 2'b00;
  logic [NCMP-1:0] cmp_hit = '0;
  logic            ext_tag = 1'b0, ibound = 1'b0, sw_trig = 1'b0, sec_bp_req = 1'b0;
  logic [1:0]      seq_state;
  logic            trig, brk_dbg, brk_swi, brk_sec;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_sequencer #(.NCMP(NCMP)) i_trig_sequencer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg(cfg), .bp_mode(bp_mode),
    .cmp_hit(cmp_hit), .ext_tag(ext_tag), .ibound(ibound), .sw_trig(sw_trig),
    .sec_bp_req(sec_bp_req), .seq_state(seq_state), .trig(trig),
    .brk_dbg(brk_dbg), .brk_swi(brk_swi), .brk_sec(brk_sec));

  function automatic logic [FW-1:0] fld(input logic tg, input logic [1:0] nx, input int sel);
    return {tg, nx, SW'(sel)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic clear_in();
    cmp_hit = '0; ext_tag = 0; ibound = 0; sw_trig = 0; sec_bp_req = 0;
  endtask

  task automatic rearm();
    clear_in();
    arm = 0; tick();
    arm = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 state", seq_state, 0);
    chk("R1 outputs", {trig, brk_dbg, brk_swi, brk_sec}, 0);
    cmp_hit = '1; ext_tag = 1; sw_trig = 1; sec_bp_req = 1; tick(); clear_in();
    chk("R1 disarmed ignores events", {seq_state, trig, brk_dbg, brk_swi, brk_sec}, 0);
  endtask

  task automatic t_tagged();
    cfg = {fld(1, 2'd3, 2), fld(1, 2'd2, NCMP), fld(1, 2'd1, 0)};
    bp_mode = 2'b01;
    rearm();
    chk("R2 idle armed", seq_state, 0);
    cmp_hit = 4'b0001; tick(); clear_in();
    chk("R2 tagged step", seq_state, 1);
    cmp_hit = 4'b1111; tick(); clear_in();
    chk("R5 comparators not selected", seq_state, 1);
    ext_tag = 1; tick(); clear_in();
    chk("R5 ext tag selected", seq_state, 2);
    cmp_hit = 4'b0100; tick(); clear_in();
    chk("R7 final entered", seq_state, 3);
    chk("R7 trig pulse", trig, 1);
    chk("R8 debug entry bp", {brk_dbg, brk_swi, brk_sec}, 3'b100);
    cmp_hit = '1; ext_tag = 1; ibound = 1; sw_trig = 1; tick(); clear_in();
    chk("R7 stays final", seq_state, 3);
    chk("R7 trig one cycle", trig, 0);
    chk("R8 bp one cycle", brk_dbg, 0);
    arm = 0; tick();
    chk("R1 disarm from final", seq_state, 0);
  endtask

  task automatic t_forced();
    cfg = {fld(1, 2'd3, 0), fld(1, 2'd3, 0), fld(0, 2'd2, 1)};
    cfg[2*FW +: FW] = fld(0, 2'd0, 3);
    rearm();
    cmp_hit = 4'b0010; ibound = 1; tick(); clear_in();
    chk("R4 same-cycle boundary", seq_state, 0);
    tick();
    chk("R3 no boundary yet", seq_state, 0);
    ibound = 1; tick(); clear_in();
    chk("R3 forced at boundary", seq_state, 2);
    cmp_hit = 4'b1000; tick(); clear_in();
    chk("R3 pending only", seq_state, 2);
    ibound = 1; tick(); clear_in();
    chk("R11 backward next", seq_state, 0);
  endtask

  task automatic t_unmapped();
    for (int s = NCMP + 1; s < (1 << SW); s++) begin
      cfg = {fld(1, 2'd3, 0), fld(1, 2'd3, 0), fld(1, 2'd2, s)};
      rearm();
      cmp_hit = '1; ext_tag = 1; ibound = 1; tick(); clear_in();
      chk("R5 unmapped select", seq_state, 0);
    end
  endtask

  task automatic t_sw();
    cfg = {fld(1, 2'd3, 0), fld(1, 2'd2, 0), fld(1, 2'd1, 0)};
    bp_mode = 2'b10;
    rearm();
    cmp_hit = 4'b0001; tick(); clear_in();
    sw_trig = 1; tick(); clear_in();
    chk("R6 sw to final", seq_state, 3);
    chk("R8 swi bp", {trig, brk_dbg, brk_swi, brk_sec}, 4'b1010);
    bp_mode = 2'b11;
    rearm();
    sw_trig = 1; cmp_hit = 4'b0001; tick(); clear_in();
    chk("R6 sw priority", seq_state, 3);
    chk("R8 second master bp", {brk_dbg, brk_swi, brk_sec}, 3'b001);
    bp_mode = 2'b00;
    rearm();
    sw_trig = 1; tick(); clear_in();
    chk("R8 no bp", {trig, brk_dbg, brk_swi, brk_sec}, 4'b1000);
  endtask

  task automatic t_disarm_pend();
    cfg = {fld(1, 2'd3, 0), fld(1, 2'd3, 0), fld(0, 2'd1, 0)};
    rearm();
    cmp_hit = 4'b0001; tick(); clear_in();
    arm = 0; tick(); arm = 1; tick();
    ibound = 1; tick(); clear_in();
    chk("R10 pending cleared", seq_state, 0);
    cmp_hit = 4'b0001; tick(); clear_in();
    ibound = 1; tick(); clear_in();
    chk("R10 works after rearm", seq_state, 1);
  endtask

  task automatic t_secbp();
    bp_mode = 2'b00;
    rearm();
    sec_bp_req = 1; tick(); clear_in();
    chk("R9 sec bp armed", brk_sec, 1);
    tick();
    chk("R9 sec bp pulse", brk_sec, 0);
    chk("R9 state untouched", seq_state, 0);
    arm = 0; sec_bp_req = 1; tick(); clear_in();
    chk("R9 sec bp disarmed", brk_sec, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #25 rst_n = 1'b1;
    tick();
    t_reset();
    t_tagged();
    t_forced();
    t_unmapped();
    t_sw();
    t_disarm_pend();
    t_secbp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule